// File: doc/BRIEF.md
# Horizontal-Control Register Datapath

This block is a bus-organized datapath built around seven general registers. Each clock it receives one 14-bit horizontal control word. Two fields of that word each pick a source for an operand bus: the external data input or one of the registers. A third field names the destination register, and a fourth selects the ALU function. The ALU result is written into the destination register on the rising clock edge.

The same result is always driven on an external output bus, even when nothing is written. A register can therefore be read out with a transfer operation and no destination. A register can be cleared by XOR-ing it with itself.

Carry and zero status are provided for the four arithmetic functions. The data width is a parameter. Control words come straight from the surrounding logic; there is no sequencing inside the block.

Top module: `cw_datapath`

## Requirements
- R1: While `rst` is high at a rising clock edge, all seven registers are cleared to zero.
- R2: `ctrlWord` bits [13:11] select the A operand, bits [10:8] select the B operand, bits [7:5] name the destination, and bits [4:0] select the ALU function.
- R3: On either source field, code 000 selects `dataIn`, and codes 001 to 111 select registers 1 to 7.
- R4: A destination code of 001 to 111 writes the ALU result into that register at the rising clock edge. Code 000 writes no register.
- R5: The ALU function codes are:
  - 00000 gives A.
  - 00001 gives A+1.
  - 00010 gives A+B.
  - 00101 gives A−B.
  - 00110 gives A−1.
  - 01000 gives A AND B.
  - 01010 gives A OR B.
  - 01100 gives A XOR B.
  - 01110 gives NOT A.
- R6: Function 10000 shifts A right by one bit, and function 11000 shifts A left by one bit. Both fill the vacated bit with zero. All arithmetic wraps modulo 2^WIDTH.
- R7: Any function code not listed in R5 or R6 yields zero. That zero is still written when the destination code is non-zero.
- R8: `busOut` combinationally shows the ALU result of the current control word and register contents, whatever the destination field holds.
- R9: For add and increment, `carryOut` is the carry out of the top bit. For subtract, `carryOut` is 1 when A < B, as unsigned values. For decrement, `carryOut` is 1 when A is zero. For these four functions, `zeroOut` is 1 when the result is zero. For every other function, both flags are 0.
- R10: Selecting the same register as both operands and as the destination, with the XOR function, leaves that register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlWord | input | 14 | Horizontal control word (A select, B select, destination, function) |
| dataIn | input | WIDTH | External operand input |
| busOut | output | WIDTH | ALU result bus |
| carryOut | output | 1 | Carry/borrow status for arithmetic functions |
| zeroOut | output | 1 | Zero-result status for arithmetic functions |

## Verification
A wrong register value stays hidden until a later control word selects that register as an operand. It then shows on `busOut` in the same cycle. A write to the wrong destination therefore appears one clock later, at the first read of either the intended register or the one that was clobbered.

For this reason the stimulus reads back every register after the writes. It also reads back the registers after no-write words and after a mid-run reset. Flag errors appear combinationally in the very cycle the arithmetic word is applied.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
  localparam int CW_BITS  = 14;
  localparam int SEL_BITS = 3;
  localparam int OP_BITS  = 5;
  localparam int NUM_REGS = 7;

  typedef enum logic [OP_BITS-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } aluOp_e;

  typedef struct packed {
    logic [SEL_BITS-1:0] srcA;
    logic [SEL_BITS-1:0] srcB;
    logic [NUM_REGS:1]   load;
    aluOp_e              op;
    logic                opKnown;
    logic                flagOp;
  } strobe_t;
endpackage

// File: rtl/cwdp_ctrl.sv
module cwdp_ctrl
  import cwdp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CW_BITS-1:0] ctrlWord,
  output strobe_t            strb
);
  logic [SEL_BITS-1:0] destSel;
  logic [OP_BITS-1:0]  opField;

  // R2: field layout
  assign destSel = ctrlWord[7:5];
  assign opField = ctrlWord[4:0];

  always_comb begin
    strb      = '0;
    strb.srcA = ctrlWord[13:11];
    strb.srcB = ctrlWord[10:8];
    // R4: destination decoder, code zero drives no load line
    for (int k = 1; k <= NUM_REGS; k++)
      strb.load[k] = (destSel == SEL_BITS'(k));
    unique case (opField)
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC, OP_AND,
      OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: begin
        strb.op      = aluOp_e'(opField);
        strb.opKnown = 1'b1;
      end
      default: begin
        strb.op      = OP_PASS;
        strb.opKnown = 1'b0;
      end
    endcase
    strb.flagOp = strb.opKnown &&
                  (strb.op == OP_ADD || strb.op == OP_SUB ||
                   strb.op == OP_INC || strb.op == OP_DEC);
  end

  // R4
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.load));
endmodule

// File: rtl/cwdp_path.sv
module cwdp_path
  import cwdp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] aluRes,
  output logic             carryOut,
  output logic             zeroOut
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [NUM_REGS:1][WIDTH-1:0] regFile;
  logic [WIDTH-1:0] busA, busB;
  logic             carryRaw;

  // R3: operand multiplexers
  always_comb begin
    busA = dataIn;
    busB = dataIn;
    for (int k = 1; k <= NUM_REGS; k++) begin
      if (strb.srcA == SEL_BITS'(k)) busA = regFile[k];
      if (strb.srcB == SEL_BITS'(k)) busB = regFile[k];
    end
  end

  // R5 R6 R7: ALU
  always_comb begin
    carryRaw = 1'b0;
    aluRes   = '0;
    if (strb.opKnown) begin
      unique case (strb.op)
        OP_PASS: aluRes = busA;
        OP_INC:  {carryRaw, aluRes} = {1'b0, busA} + {1'b0, ONE};
        OP_ADD:  {carryRaw, aluRes} = {1'b0, busA} + {1'b0, busB};
        OP_SUB:  begin aluRes = busA - busB; carryRaw = busA < busB; end
        OP_DEC:  begin aluRes = busA - ONE;  carryRaw = busA == '0;  end
        OP_AND:  aluRes = busA & busB;
        OP_OR:   aluRes = busA | busB;
        OP_XOR:  aluRes = busA ^ busB;
        OP_NOT:  aluRes = ~busA;
        OP_SHR:  aluRes = {1'b0, busA[WIDTH-1:1]};
        OP_SHL:  aluRes = {busA[WIDTH-2:0], 1'b0};
        default: aluRes = '0;
      endcase
    end
  end

  // R9
  assign carryOut = strb.flagOp && carryRaw;
  assign zeroOut  = strb.flagOp && (aluRes == '0);

  // R1 R4: register bank
  generate
    for (genvar k = 1; k <= NUM_REGS; k++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)               regFile[k] <= '0;
        else if (strb.load[k]) regFile[k] <= aluRes;
      end
      // R4
      write_dest_chk: assert property (@(posedge clk) disable iff (rst)
        strb.load[k] |=> (regFile[k] == $past(aluRes)));
    end
  endgenerate

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (regFile == '0));
  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(|strb.load) |=> $stable(regFile));
  // R9
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.flagOp |-> (!carryOut && !zeroOut));
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cwdp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [13:0]      ctrlWord,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] busOut,
  output logic             carryOut,
  output logic             zeroOut
);
  strobe_t strb;

  cwdp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctrlWord(ctrlWord),
    .strb    (strb)
  );

  cwdp_path #(.WIDTH(WIDTH)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .dataIn  (dataIn),
    .aluRes  (busOut),
    .carryOut(carryOut),
    .zeroOut (zeroOut)
  );
endmodule

// File: tb/cw_datapath_test.sv
module cw_datapath_test;
  localparam int W = 8;
  localparam int NV = 26;

  logic         clk = 1'b0;
  logic         rst;
  logic [13:0]  ctrlWord;
  logic [W-1:0] dataIn;
  logic [W-1:0] busOut;
  logic         carryOut, zeroOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  cw_datapath #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .dataIn(dataIn),
    .busOut(busOut), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  always #10 clk = ~clk;

  // {A sel, B sel, dest, function, dataIn, expected out, carry, zero}
  localparam logic [31:0] VEC [0:NV-1] = '{
    {3'd0,3'd0,3'd1,5'b00000, 8'h05, 8'h05, 1'b0,1'b0}, // R3 R1<-in
    {3'd0,3'd0,3'd2,5'b00000, 8'h03, 8'h03, 1'b0,1'b0}, // R2<-in
    {3'd1,3'd2,3'd3,5'b00010, 8'h00, 8'h08, 1'b0,1'b0}, // R5 add
    {3'd2,3'd3,3'd4,5'b00101, 8'h00, 8'hFB, 1'b1,1'b0}, // R9 sub borrow
    {3'd1,3'd4,3'd5,5'b01000, 8'h00, 8'h01, 1'b0,1'b0}, // and
    {3'd2,3'd3,3'd6,5'b01010, 8'h00, 8'h0B, 1'b0,1'b0}, // or
    {3'd6,3'd0,3'd7,5'b01100, 8'hFF, 8'hF4, 1'b0,1'b0}, // xor with input on B
    {3'd7,3'd0,3'd1,5'b01110, 8'h00, 8'h0B, 1'b0,1'b0}, // not
    {3'd7,3'd0,3'd2,5'b10000, 8'h00, 8'h7A, 1'b0,1'b0}, // R6 shr
    {3'd7,3'd0,3'd3,5'b11000, 8'h00, 8'hE8, 1'b0,1'b0}, // R6 shl
    {3'd0,3'd0,3'd0,5'b00001, 8'hFF, 8'h00, 1'b1,1'b1}, // R6 inc wrap
    {3'd0,3'd0,3'd0,5'b00110, 8'h00, 8'hFF, 1'b1,1'b0}, // dec wrap
    {3'd1,3'd1,3'd0,5'b00101, 8'h00, 8'h00, 1'b0,1'b1}, // sub zero
    {3'd3,3'd3,3'd4,5'b00010, 8'h00, 8'hD0, 1'b1,1'b0}, // add carry
    {3'd1,3'd2,3'd5,5'b00011, 8'h00, 8'h00, 1'b0,1'b0}, // R7 unlisted writes 0
    {3'd6,3'd6,3'd6,5'b01100, 8'h00, 8'h00, 1'b0,1'b0}, // R10 clear
    {3'd4,3'd0,3'd0,5'b00000, 8'h00, 8'hD0, 1'b0,1'b0}, // R8 readback
    {3'd5,3'd0,3'd0,5'b00000, 8'h00, 8'h00, 1'b0,1'b0}, // R7 readback
    {3'd6,3'd0,3'd0,5'b00000, 8'h00, 8'h00, 1'b0,1'b0}, // R10 readback
    {3'd1,3'd0,3'd0,5'b00000, 8'h00, 8'h0B, 1'b0,1'b0},
    {3'd2,3'd0,3'd0,5'b00000, 8'h00, 8'h7A, 1'b0,1'b0},
    {3'd3,3'd0,3'd0,5'b00000, 8'h00, 8'hE8, 1'b0,1'b0},
    {3'd7,3'd0,3'd0,5'b00000, 8'h00, 8'hF4, 1'b0,1'b0}, // R4 no-write held
    {3'd2,3'd0,3'd0,5'b00110, 8'h00, 8'h79, 1'b0,1'b0},
    {3'd7,3'd0,3'd7,5'b00001, 8'h00, 8'hF5, 1'b0,1'b0},
    {3'd7,3'd0,3'd0,5'b00000, 8'h00, 8'hF5, 1'b0,1'b0}  // R2 field order
  };

  task automatic applyCheck(input logic [13:0] cw, input logic [W-1:0] din,
                            input logic [W-1:0] expOut, input logic expC,
                            input logic expZ, input string tag);
    @(negedge clk);
    ctrlWord = cw;
    dataIn   = din;
    #5;
    nChecks++;
    if (busOut !== expOut || carryOut !== expC || zeroOut !== expZ) begin
      nFails++;
      $display("FAIL %s: out=%h c=%b z=%b, expected out=%h c=%b z=%b",
               tag, busOut, carryOut, zeroOut, expOut, expC, expZ);
    end
  endtask

  initial begin
    rst = 1'b1;
    ctrlWord = '0;
    dataIn = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state of every register
    for (int k = 1; k <= 7; k++)
      applyCheck({3'(k), 3'd0, 3'd0, 5'b00000}, 8'h00, 8'h00, 1'b0, 1'b0,
                 "R1 reset state");

    for (int i = 0; i < NV; i++)
      applyCheck(VEC[i][31:18], VEC[i][17:10], VEC[i][9:2], VEC[i][1],
                 VEC[i][0], $sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R10 vector %0d", i));

    // R4: no-destination word must not disturb R1
    applyCheck({3'd0, 3'd0, 3'd0, 5'b00000}, 8'h55, 8'h55, 1'b0, 1'b0,
               "R8 input pass, no write");
    applyCheck({3'd1, 3'd0, 3'd0, 5'b00000}, 8'h00, 8'h0B, 1'b0, 1'b0,
               "R4 R1 unchanged");

    // R1: mid-run reset clears everything
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int k = 1; k <= 7; k++)
      applyCheck({3'(k), 3'd0, 3'd0, 5'b00000}, 8'h00, 8'h00, 1'b0, 1'b0,
                 "R1 mid-run reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule